// File: doc/BRIEF.md
# Mode-Selected Synchronous Clock Divider Tree

This block takes one fast source clock, which stands in for a frequency synthesizer output, and divides it into a family of phase-related clocks. The family has a processor-rate clock, a memory reference clock at half that rate, a mid-rate fixed clock, a bus clock and a slow interrupt-controller clock. It also has a USB-rate clock and a registered copy of an external reference input. All of the divided clocks come from one set of counters on the source clock. Their rising edges therefore line up wherever the ratios allow it.

A three-bit mode word chooses how the block behaves. The mode word is built from a rate-select bit (bit 2) and two function bits (bits 1 and 0). The block can put every output into high impedance for board testing. It can park every output low for the two reserved codes. It can run a test mode in which a slower test clock, driven from outside, is divided by fixed powers of two. In the two running modes, the rate bit picks the fast or slow processor rate, and bit 0 decides whether the USB-rate output is driven. High impedance is modelled as an output-enable pin next to each clock, so the pad ring can do the actual three-stating. A new mode word is accepted only once it has been seen on two source-clock edges in a row. When a new mode is accepted, every divider restarts together.

Top module: `clkdiv_tree`

## Requirements
- R1: While reset is asserted, and until a mode other than 000 has been accepted, every output enable is 0 and every clock output is 0.
- R2: Mode 000: every output enable is 0 and every clock output is held at 0.
- R3: Modes 001 and 101 are reserved. Every output enable is 1 and every clock output stays at 0.
- R4: Mode 100 is test mode, and every enable is 1. The periods, counted in test-clock periods, are: reference 1, processor 2, memory 2×2, mid-rate 4, bus 8, USB-rate 2 and interrupt 16.
- R5: Modes 110 and 111 are the fast running modes. The periods in source cycles are: processor 6, memory 12, mid-rate 12, bus 24 and interrupt 48. The reference output follows ref_i one source cycle later.
- R6: Modes 010 and 011 are the slow running modes. The periods in source cycles are: processor 8, memory 16, mid-rate 12, bus 24 and interrupt 48. The reference output follows ref_i one source cycle later.
- R7: In the running modes, usb_oe equals mode bit 0. When bit 0 is 1, the USB-rate clock has a period of 16 source cycles. When bit 0 is 0, it is held at 0.
- R8: In the running modes, the memory clock runs at half the processor rate. Every rising edge of the memory clock and of the bus clock falls on a rising edge of the processor clock. Every rising edge of the interrupt clock falls on a rising edge of the bus clock.
- R9: A mode word is accepted on the second of two consecutive source edges that sample the same value. A value that is present for only one edge is ignored.
- R10: When a running mode is accepted, all divided clocks restart together. In the cycle after acceptance, the processor, memory, mid-rate, bus, interrupt and enabled USB-rate clocks are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock (synthesizer stand-in) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode word {rate select, function bit 1, function bit 0} |
| tclk_i | input | 1 | External test clock, much slower than clk_src |
| ref_i | input | 1 | Reference clock input for pass-through |
| cpu_o | output | 1 | Processor-rate clock |
| cpu_oe | output | 1 | Drive enable for cpu_o |
| mem_o | output | 1 | Half-rate memory reference clock |
| mem_oe | output | 1 | Drive enable for mem_o |
| mid_o | output | 1 | Mid-rate fixed clock |
| mid_oe | output | 1 | Drive enable for mid_o |
| bus_o | output | 1 | Bus clock |
| bus_oe | output | 1 | Drive enable for bus_o |
| irq_o | output | 1 | Interrupt-controller clock |
| irq_oe | output | 1 | Drive enable for irq_o |
| usb_o | output | 1 | USB-rate clock |
| usb_oe | output | 1 | Drive enable for usb_o |
| ref_o | output | 1 | Reference copy (test clock in test mode) |
| ref_oe | output | 1 | Drive enable for ref_o |

## Verification
The hardest behaviour to reach from the ports is the mode filter. A mode word that lasts exactly one source edge must leave the block unchanged, while a word that lasts two edges must take effect on the second edge, and in that same cycle every divider must restart high. The bench reaches these cases by driving mode_i on the falling edge and holding it for one edge or for two edges. It then samples the enables and clock levels one cycle apart. The rate checks count rising edges over a window that is a whole multiple of every period in the mode. The count is therefore exact whatever the starting phase. The test clock is placed so that its edges never coincide with source-clock edges, which keeps its synchronized count deterministic.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        MK_HIZ,
        MK_RSV,
        MK_TEST,
        MK_RUN
    } mode_kind_t;

    // divider slots
    localparam int NDIV    = 6;
    localparam int DIV_CPU = 0;
    localparam int DIV_MEM = 1;
    localparam int DIV_MID = 2;
    localparam int DIV_BUS = 3;
    localparam int DIV_IRQ = 4;
    localparam int DIV_USB = 5;

    function automatic mode_kind_t decode_mode(input logic [2:0] m);
        mode_kind_t k;
        case (m)
            3'b000:         k = MK_HIZ;
            3'b001, 3'b101: k = MK_RSV;
            3'b100:         k = MK_TEST;
            default:        k = MK_RUN;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/clkdiv_mode_sync.sv
module clkdiv_mode_sync #(
    parameter int MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode_i,
    output logic [MW-1:0] mode_o,
    output logic          restart_o
);

    typedef struct packed {
        logic [MW-1:0] samp;
        logic [MW-1:0] cur;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     accept;

    always_comb begin
        st_d      = st_q;
        accept    = (mode_i == st_q.samp) && (mode_i != st_q.cur);
        st_d.samp = mode_i;
        if (accept) begin
            st_d.cur = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.cur;
    assign restart_o = accept;

    // R9: a new mode must have been on the input for the two edges before it appears
    p_two_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != $past(st_q.cur)) |->
            (($past(mode_i) == st_q.cur) && ($past(mode_i, 2) == st_q.cur)));

endmodule

// File: rtl/clkdiv_toggle.sv
module clkdiv_toggle #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] half_i,
    output logic          clk_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } tog_st_t;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b1;
        end else if (st_q.cnt == half_i - CW'(1)) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, lvl: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.lvl;

    // R6: the half-period counter never passes the selected half period
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (st_q.cnt < half_i));

endmodule

// File: rtl/clkdiv_test_div.sv
module clkdiv_test_div #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tclk_i,
    output logic          tref_o,
    output logic [TW-1:0] tcnt_o
);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [TW-1:0] cnt;
    } tdiv_st_t;

    tdiv_st_t st_d, st_q;
    logic     t_rise;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = tclk_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        t_rise  = st_q.s2 & ~st_q.s3;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (t_rise) begin
            st_d.cnt = st_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tref_o = st_q.s2;
    assign tcnt_o = st_q.cnt;

    // R4: the count advances by at most one per source cycle and only on a test-clock rise
    p_step_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) && !$past(clr_i) |->
            (st_q.cnt == $past(st_q.cnt) + TW'(1)));

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_pkg::*;
#(
    parameter int CPU_HALF_FAST = 3,
    parameter int CPU_HALF_SLOW = 4,
    parameter int MID_HALF      = 6,
    parameter int BUS_HALF      = 12,
    parameter int IRQ_HALF      = 24,
    parameter int USB_HALF      = 8
) (
    input  logic       clk_src,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       tclk_i,
    input  logic       ref_i,
    output logic       cpu_o,
    output logic       cpu_oe,
    output logic       mem_o,
    output logic       mem_oe,
    output logic       mid_o,
    output logic       mid_oe,
    output logic       bus_o,
    output logic       bus_oe,
    output logic       irq_o,
    output logic       irq_oe,
    output logic       usb_o,
    output logic       usb_oe,
    output logic       ref_o,
    output logic       ref_oe
);

    localparam int CW = $clog2(4 * IRQ_HALF + 1);
    localparam int TW = 4;

    typedef struct packed {
        logic ref_lvl;
    } top_st_t;

    top_st_t      st_d, st_q;
    logic [2:0]   mode_q;
    logic         restart;
    mode_kind_t   kind;
    logic         run_now;
    logic         test_now;
    logic [CW-1:0] half_sel [NDIV];
    logic [NDIV-1:0] div_clk;
    logic         tref;
    logic [TW-1:0] tcnt;

    clkdiv_mode_sync #(.MW(3)) u_sync (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .mode_o    (mode_q),
        .restart_o (restart)
    );

    assign kind     = decode_mode(mode_q);
    assign run_now  = (kind == MK_RUN);
    assign test_now = (kind == MK_TEST);

    always_comb begin
        half_sel[DIV_CPU] = mode_q[2] ? CW'(CPU_HALF_FAST) : CW'(CPU_HALF_SLOW);
        half_sel[DIV_MEM] = mode_q[2] ? CW'(2 * CPU_HALF_FAST) : CW'(2 * CPU_HALF_SLOW);
        half_sel[DIV_MID] = CW'(MID_HALF);
        half_sel[DIV_BUS] = CW'(BUS_HALF);
        half_sel[DIV_IRQ] = CW'(IRQ_HALF);
        half_sel[DIV_USB] = CW'(USB_HALF);
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        clkdiv_toggle #(.CW(CW)) u_div (
            .clk    (clk_src),
            .rst_n  (rst_n),
            .clr_i  (restart),
            .half_i (half_sel[g]),
            .clk_o  (div_clk[g])
        );
    end

    clkdiv_test_div #(.TW(TW)) u_tdiv (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .clr_i  (restart),
        .tclk_i (tclk_i),
        .tref_o (tref),
        .tcnt_o (tcnt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ref_lvl = ref_i;
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpu_o  = 1'b0;
        mem_o  = 1'b0;
        mid_o  = 1'b0;
        bus_o  = 1'b0;
        irq_o  = 1'b0;
        usb_o  = 1'b0;
        ref_o  = 1'b0;
        cpu_oe = (kind != MK_HIZ);
        mem_oe = cpu_oe;
        mid_oe = cpu_oe;
        bus_oe = cpu_oe;
        irq_oe = cpu_oe;
        ref_oe = cpu_oe;
        usb_oe = run_now ? mode_q[0] : cpu_oe;
        case (kind)
            MK_TEST: begin
                ref_o = tref;
                cpu_o = tcnt[0];
                usb_o = tcnt[0];
                mem_o = tcnt[1];
                mid_o = tcnt[1];
                bus_o = tcnt[2];
                irq_o = tcnt[3];
            end
            MK_RUN: begin
                cpu_o = div_clk[DIV_CPU];
                mem_o = div_clk[DIV_MEM];
                mid_o = div_clk[DIV_MID];
                bus_o = div_clk[DIV_BUS];
                irq_o = div_clk[DIV_IRQ];
                usb_o = mode_q[0] & div_clk[DIV_USB];
                ref_o = st_q.ref_lvl;
            end
            default: ;
        endcase
    end

    // R8: memory clock rises only together with the processor clock
    p_mem_on_cpu_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        (run_now && (mode_q == $past(mode_q)) && $rose(mem_o)) |-> $rose(cpu_o));

    // R8: bus clock rises only together with the processor clock
    p_bus_on_cpu_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        (run_now && (mode_q == $past(mode_q)) && $rose(bus_o)) |-> $rose(cpu_o));

    // R8: interrupt clock rises only together with the bus clock
    p_irq_on_bus_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        (run_now && (mode_q == $past(mode_q)) && $rose(irq_o)) |-> $rose(bus_o));

    // R4: in test mode the quarter-rate clock rises as the half-rate clock falls
    p_test_ratio_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
        (test_now && (mode_q == $past(mode_q)) && $rose(mem_o)) |-> $fell(cpu_o));

endmodule

// File: tb/clkdiv_tree_bench.sv
module clkdiv_tree_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'b000;
    logic       tclk_i = 1'b0;
    logic       ref_i = 1'b0;
    logic cpu_o, cpu_oe, mem_o, mem_oe, mid_o, mid_oe, bus_o, bus_oe;
    logic irq_o, irq_oe, usb_o, usb_oe, ref_o, ref_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int rc [7];
    int mis;

    clkdiv_tree u_clkdiv_tree (
        .clk_src (clk),   .rst_n  (rst_n),  .mode_i (mode_i),
        .tclk_i  (tclk_i), .ref_i (ref_i),
        .cpu_o (cpu_o), .cpu_oe (cpu_oe), .mem_o (mem_o), .mem_oe (mem_oe),
        .mid_o (mid_o), .mid_oe (mid_oe), .bus_o (bus_o), .bus_oe (bus_oe),
        .irq_o (irq_o), .irq_oe (irq_oe), .usb_o (usb_o), .usb_oe (usb_oe),
        .ref_o (ref_o), .ref_oe (ref_oe)
    );

    // order: cpu, mem, mid, bus, irq, usb, ref
    logic [6:0] outs, oes;
    assign outs = {ref_o, usb_o, irq_o, bus_o, mid_o, mem_o, cpu_o};
    assign oes  = {ref_oe, usb_oe, irq_oe, bus_oe, mid_oe, mem_oe, cpu_oe};

    always #5 clk = ~clk;                  // 100 MHz source
    initial begin #3; forever #40 tclk_i = ~tclk_i; end   // 8 source cycles
    initial begin #2; forever #70 ref_i = ~ref_i; end     // 14 source cycles

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        report();
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [2:0] m, input int idx);
        int p [7];
        p = '{0, 0, 0, 0, 0, 0, 0};
        if (m == 3'b100) begin
            p = '{16, 32, 32, 64, 128, 16, 8};
        end else if (m[1]) begin
            p[0] = m[2] ? 6 : 8;
            p[1] = 2 * p[0];
            p[2] = 12;
            p[3] = 24;
            p[4] = 48;
            p[5] = m[0] ? 16 : 0;
            p[6] = 14;
        end
        return p[idx];
    endfunction

    function automatic string tag_of(input logic [2:0] m, input int idx);
        if (m == 3'b000) return "R2";
        if (m == 3'b001 || m == 3'b101) return "R3";
        if (m == 3'b100) return "R4";
        if (idx == 5) return "R7";
        return m[2] ? "R5" : "R6";
    endfunction

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_i = m;
    endtask

    task automatic measure(input int w);
        logic [6:0] prev;
        for (int i = 0; i < 7; i++) rc[i] = 0;
        mis  = 0;
        prev = outs;
        repeat (w) begin
            @(negedge clk);
            for (int i = 0; i < 7; i++) begin
                if (outs[i] && !prev[i]) rc[i]++;
            end
            if (outs[3] && !prev[3] && !(outs[0] && !prev[0])) mis++;
            prev = outs;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "enables in reset", int'(oes), 0);
        chk("R1", "clocks in reset", int'(outs), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "enables after reset", int'(oes), 0);

        // R9: a one-edge mode pulse is ignored
        mode_i = 3'b111;
        @(negedge clk);
        mode_i = 3'b000;
        repeat (4) @(negedge clk);
        chk("R9", "enables after one-edge pulse", int'(oes), 0);

        // R9: a held mode takes effect on the second edge
        mode_i = 3'b111;
        @(negedge clk);
        chk("R9", "cpu_oe after first edge", int'(cpu_oe), 0);
        @(negedge clk);
        chk("R9", "cpu_oe after second edge", int'(cpu_oe), 1);
        // R10: all divided clocks high right after acceptance
        chk("R10", "divided clocks after restart", int'(outs[5:0]), 6'h3f);

        // sweep every mode code
        for (int m = 0; m < 8; m++) begin
            logic [2:0] mc;
            int w;
            mc = 3'(m);
            set_mode(mc);
            repeat (6) @(negedge clk);
            w = (mc == 3'b100) ? 512 : 336;
            measure(w);
            for (int i = 0; i < 7; i++) begin
                int eoe, per;
                if (mc == 3'b000) eoe = 0;
                else if (i == 5 && mc[1]) eoe = int'(mc[0]);
                else eoe = 1;
                per = exp_period(mc, i);
                chk(tag_of(mc, i), $sformatf("mode %03b enable %0d", mc, i),
                    int'(oes[i]), eoe);
                chk(tag_of(mc, i), $sformatf("mode %03b rising edges %0d", mc, i),
                    rc[i], (per == 0) ? 0 : w / per);
            end
            if (mc[1]) begin
                chk("R8", $sformatf("mode %03b bus edges off cpu edges", mc), mis, 0);
            end
            if (mc == 3'b000 || mc == 3'b001 || mc == 3'b101) begin
                chk(tag_of(mc, 0), $sformatf("mode %03b clock levels", mc), int'(outs), 0);
            end
        end

        report();
    end

endmodule